// File: doc/BRIEF.md
# Pipelined Key Search Controller

This block turns a fully pipelined block-cipher datapath into an exhaustive key trial engine. The host loads one known plaintext/ciphertext pair, a start key and an end key. After a start pulse, the controller hands the datapath one fresh 56-bit trial key and the shared plaintext on every clock. The start and end values let many copies of the unit each cover their own slice of the key space. The cipher rounds sit outside the block. The datapath must return its result a fixed `LAT` cycles after a slot is presented.

Each launched key also travels down a shift pipeline inside the controller, `LAT` stages deep. That pipeline stays in step with the datapath, so the key leaving it always belongs to the result arriving on `dp_res_i`. Each result is compared with the stored ciphertext. On the first hit the key is latched and an interrupt goes up. The sweep carries on regardless, because several keys can map the same pair. A further hit while the interrupt is still pending raises an overflow flag.

The host can insert a self-test at any point of a run. One slot carrying a built-in key and plaintext is pushed through the datapath, and its result is checked against a built-in ciphertext. Normal launching pauses until that result returns, and then resumes exactly where it stopped.

Top module: `key_search_ctrl`

## Requirements
- R1: After reset `dp_vld_o`, `done_o`, `irq_o`, `overflow_o` and `bist_done_o` are all 0.
- R2: A `go_i` pulse loads the counter from `start_key_i` and clears `done_o`. From then on one search key is launched per clock, ascending by one (modulo 2^56). `go_i` is ignored while a self-test is in flight.
- R3: The end key is launched and is the last search key. Launching then stops. `done_o` rises only once every launched key has left the key pipeline and been compared, and it stays high until the next `go_i`.
- R4: The result on `dp_res_i` arriving `LAT` cycles after a search slot is compared with the ciphertext stored by `load_pair_i`. On equality `irq_o` is set and `hit_key_o` takes the key of that slot.
- R5: A hit does not stop the run. `hit_key_o` holds the captured key until `irq_clr_i`.
- R6: A hit while `irq_o` is high, with no clear in the same cycle, sets `overflow_o` and keeps the first captured key. `irq_clr_i` clears both `irq_o` and `overflow_o`.
- R7: `bist_req_i`, taken while idle or running, launches one test slot with the built-in key and plaintext. No search key is launched until that slot's result returns. Searching then resumes with the next untried key, with none skipped or repeated.
- R8: The returning test result sets `bist_done_o`, and `bist_pass_o` shows whether it equals the built-in ciphertext. A test slot never raises `irq_o`, even when its result equals the stored target.
- R9: Every search slot carries the stored plaintext on `dp_text_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_pair_i | input | 1 | Store `pair_pt_i` and `pair_ct_i` |
| pair_pt_i | input | 64 | Known plaintext |
| pair_ct_i | input | 64 | Target ciphertext |
| start_key_i | input | 56 | First key of this unit's slice |
| end_key_i | input | 56 | Last key of this unit's slice |
| go_i | input | 1 | Start a sweep |
| bist_req_i | input | 1 | Request one self-test slot |
| irq_clr_i | input | 1 | Clear interrupt and overflow |
| dp_vld_o | output | 1 | A slot is presented to the datapath |
| dp_key_o | output | 56 | Trial key for the datapath |
| dp_text_o | output | 64 | Plaintext for the datapath |
| dp_res_i | input | 64 | Datapath result, `LAT` cycles after the slot |
| done_o | output | 1 | Sweep finished and drained |
| irq_o | output | 1 | Match interrupt |
| hit_key_o | output | 56 | Captured matching key |
| overflow_o | output | 1 | Extra match while interrupt pending |
| bist_done_o | output | 1 | Self-test result available |
| bist_pass_o | output | 1 | Self-test result was correct |

## Verification
The bench puts a toy 16-stage cipher in front of the block in which each even/odd key pair collides. A target placed on one key of such a pair therefore yields two hits, and those separate first-key capture from overflow. A target whose partner key lies just outside the slice yields a single hit, and one on the very last key shows whether the drain finishes before `done_o`. Targets that are impossible by construction show that nothing fires spuriously.

Random slices with self-tests dropped in at random points check that the key stream stays gap-free across the pause. A target set equal to the built-in ciphertext shows that test slots are never compared against the target. An injected datapath fault tells a passing self-test from a failing one.

// File: rtl/ks_pkg.sv
package ks_pkg;

   typedef enum logic [2:0] {
      KS_IDLE  = 3'd0,
      KS_RUN   = 3'd1,
      KS_DRAIN = 3'd2,
      KS_TEST  = 3'd3
   } ks_state_e;

endpackage

// File: rtl/ks_keygen.sv
module ks_keygen
   import ks_pkg::*;
#(
   parameter int KEY_W = 56,
   parameter int BLK_W = 64,
   parameter logic [KEY_W-1:0] BIST_KEY = '0,
   parameter logic [BLK_W-1:0] BIST_PT  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] start_key,
   input  logic [KEY_W-1:0] end_key,
   input  logic             go,
   input  logic             bist_req,
   input  logic [BLK_W-1:0] pt,
   input  logic             pipe_busy,
   input  logic             test_back,
   output logic             vld_q,
   output logic             test_q,
   output logic [KEY_W-1:0] key_q,
   output logic [BLK_W-1:0] text_q,
   output logic             done_q
);

   ks_state_e        state, ret_state;
   logic [KEY_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= KS_IDLE;
         ret_state <= KS_IDLE;
         cnt       <= '0;
         vld_q     <= 1'b0;
         test_q    <= 1'b0;
         key_q     <= '0;
         text_q    <= '0;
         done_q    <= 1'b0;
      end else begin
         vld_q  <= 1'b0;
         test_q <= 1'b0;
         if (go && state != KS_TEST) begin
            cnt    <= start_key;
            state  <= KS_RUN;
            done_q <= 1'b0;
         end else begin
            case (state)
               KS_IDLE: begin
                  if (bist_req) begin
                     vld_q     <= 1'b1;
                     test_q    <= 1'b1;
                     key_q     <= BIST_KEY;
                     text_q    <= BIST_PT;
                     ret_state <= KS_IDLE;
                     state     <= KS_TEST;
                  end
               end
               KS_RUN: begin
                  if (bist_req) begin
                     vld_q     <= 1'b1;
                     test_q    <= 1'b1;
                     key_q     <= BIST_KEY;
                     text_q    <= BIST_PT;
                     ret_state <= KS_RUN;
                     state     <= KS_TEST;
                  end else begin
                     vld_q  <= 1'b1;
                     key_q  <= cnt;
                     text_q <= pt;
                     if (cnt == end_key) state <= KS_DRAIN;
                     else                cnt   <= cnt + KEY_W'(1);
                  end
               end
               KS_DRAIN: begin
                  if (!vld_q && !pipe_busy) begin
                     done_q <= 1'b1;
                     state  <= KS_IDLE;
                  end
               end
               KS_TEST: begin
                  if (test_back) state <= ret_state;
               end
               default: state <= KS_IDLE;
            endcase
         end
      end
   end

   AST_KEY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !test_q && $past(vld_q && !test_q) && !$past(go))
      |-> (key_q == $past(key_q) + KEY_W'(1))); // R2

   AST_TEST_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == KS_TEST) |-> !(vld_q && !test_q)); // R7

endmodule

// File: rtl/ks_keypipe.sv
module ks_keypipe #(
   parameter int KEY_W = 56,
   parameter int LAT   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic             in_test,
   input  logic [KEY_W-1:0] in_key,
   output logic             out_vld,
   output logic             out_test,
   output logic [KEY_W-1:0] out_key,
   output logic             busy
);

   if (LAT < 2) begin : g_bad_lat
      $error("ks_keypipe: LAT must be at least 2");
   end

   logic [LAT-1:0]   v_w;
   logic [LAT-1:0]   t_w;
   logic [KEY_W-1:0] k_w [LAT];

   for (genvar i = 0; i < LAT; i++) begin : g_stg
      logic             v, t;
      logic [KEY_W-1:0] k;
      logic             v_in, t_in;
      logic [KEY_W-1:0] k_in;

      if (i == 0) begin : g_head
         assign v_in = in_vld;
         assign t_in = in_test;
         assign k_in = in_key;
      end else begin : g_body
         assign v_in = v_w[i-1];
         assign t_in = t_w[i-1];
         assign k_in = k_w[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v <= 1'b0;
            t <= 1'b0;
            k <= '0;
         end else begin
            v <= v_in;
            t <= t_in;
            k <= k_in;
         end
      end

      assign v_w[i] = v;
      assign t_w[i] = t;
      assign k_w[i] = k;
   end

   assign out_vld  = v_w[LAT-1];
   assign out_test = t_w[LAT-1];
   assign out_key  = k_w[LAT-1];
   assign busy     = |v_w;

endmodule

// File: rtl/ks_match.sv
module ks_match #(
   parameter int KEY_W = 56,
   parameter int BLK_W = 64,
   parameter logic [BLK_W-1:0] BIST_CT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_vld,
   input  logic             slot_test,
   input  logic [KEY_W-1:0] slot_key,
   input  logic [BLK_W-1:0] res,
   input  logic [BLK_W-1:0] target,
   input  logic             irq_clr,
   input  logic             test_launch,
   output logic             irq,
   output logic [KEY_W-1:0] cap_key,
   output logic             ovf,
   output logic             bist_done,
   output logic             bist_pass
);

   logic hit, test_ret;

   assign hit      = slot_vld && !slot_test && (res == target);
   assign test_ret = slot_vld && slot_test;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         ovf     <= 1'b0;
         cap_key <= '0;
      end else if (hit) begin
         if (irq && !irq_clr) begin
            ovf <= 1'b1;
         end else begin
            irq     <= 1'b1;
            cap_key <= slot_key;
            if (irq_clr) ovf <= 1'b0;
         end
      end else if (irq_clr) begin
         irq <= 1'b0;
         ovf <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bist_done <= 1'b0;
         bist_pass <= 1'b0;
      end else if (test_ret) begin
         bist_done <= 1'b1;
         bist_pass <= (res == BIST_CT);
      end else if (test_launch) begin
         bist_done <= 1'b0;
      end
   end

   AST_KEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(irq) && !$past(irq_clr)) |-> $stable(cap_key)); // R5

   AST_OVF_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> irq); // R6

   AST_TEST_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(slot_vld && !slot_test)); // R8

endmodule

// File: rtl/key_search_ctrl.sv
module key_search_ctrl
   import ks_pkg::*;
#(
   parameter int KEY_W = 56,
   parameter int BLK_W = 64,
   parameter int LAT   = 16,
   parameter logic [KEY_W-1:0] BIST_KEY = 56'h3C_9A17_0E55_D2B4,
   parameter logic [BLK_W-1:0] BIST_PT  = 64'h6D21_F0C3_8847_1AE9,
   parameter logic [BLK_W-1:0] BIST_CT  = 64'h91B4_27E6_05DA_7C38
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_pair_i,
   input  logic [BLK_W-1:0] pair_pt_i,
   input  logic [BLK_W-1:0] pair_ct_i,
   input  logic [KEY_W-1:0] start_key_i,
   input  logic [KEY_W-1:0] end_key_i,
   input  logic             go_i,
   input  logic             bist_req_i,
   input  logic             irq_clr_i,
   output logic             dp_vld_o,
   output logic [KEY_W-1:0] dp_key_o,
   output logic [BLK_W-1:0] dp_text_o,
   input  logic [BLK_W-1:0] dp_res_i,
   output logic             done_o,
   output logic             irq_o,
   output logic [KEY_W-1:0] hit_key_o,
   output logic             overflow_o,
   output logic             bist_done_o,
   output logic             bist_pass_o
);

   if (KEY_W < 2 || KEY_W > BLK_W) begin : g_bad_width
      $error("key_search_ctrl: KEY_W must lie in 2..BLK_W");
   end

   logic [BLK_W-1:0] pt_q, ct_q;
   logic             test_q;
   logic             out_vld, out_test, pipe_busy;
   logic [KEY_W-1:0] out_key;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pt_q <= '0;
         ct_q <= '0;
      end else if (load_pair_i) begin
         pt_q <= pair_pt_i;
         ct_q <= pair_ct_i;
      end
   end

   ks_keygen #(
      .KEY_W(KEY_W), .BLK_W(BLK_W), .BIST_KEY(BIST_KEY), .BIST_PT(BIST_PT)
   ) u_gen (
      .clk(clk), .rst_n(rst_n),
      .start_key(start_key_i), .end_key(end_key_i),
      .go(go_i), .bist_req(bist_req_i), .pt(pt_q),
      .pipe_busy(pipe_busy), .test_back(out_vld && out_test),
      .vld_q(dp_vld_o), .test_q(test_q), .key_q(dp_key_o),
      .text_q(dp_text_o), .done_q(done_o)
   );

   ks_keypipe #(.KEY_W(KEY_W), .LAT(LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n),
      .in_vld(dp_vld_o), .in_test(test_q), .in_key(dp_key_o),
      .out_vld(out_vld), .out_test(out_test), .out_key(out_key),
      .busy(pipe_busy)
   );

   ks_match #(.KEY_W(KEY_W), .BLK_W(BLK_W), .BIST_CT(BIST_CT)) u_match (
      .clk(clk), .rst_n(rst_n),
      .slot_vld(out_vld), .slot_test(out_test), .slot_key(out_key),
      .res(dp_res_i), .target(ct_q), .irq_clr(irq_clr_i),
      .test_launch(dp_vld_o && test_q),
      .irq(irq_o), .cap_key(hit_key_o), .ovf(overflow_o),
      .bist_done(bist_done_o), .bist_pass(bist_pass_o)
   );

   AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (!pipe_busy && !dp_vld_o)); // R3

endmodule

// File: tb/key_search_ctrl_test.sv
`timescale 1ns/1ps
module key_search_ctrl_test;

   localparam int LAT = 16;
   localparam logic [55:0] BKEY = 56'h00A5_5A00_0F0F_33;
   localparam logic [63:0] BPT  = 64'hFEED_0000_1234_5678;
   localparam logic [63:0] BCT  = BPT ^ {8'h00, BKEY[55:1], 1'b0};

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        load_pair = 0, go = 0, bist_req = 0, irq_clr = 0;
   logic [63:0] pair_pt = '0, pair_ct = '0;
   logic [55:0] start_key = '0, end_key = '0;
   logic        dp_vld, done, irq, ovf, bdone, bpass;
   logic [55:0] dp_key, hit_key;
   logic [63:0] dp_text, dp_res;
   logic        fault = 1'b0;

   int vectors = 0, fails = 0, cyc = 0;
   int mon_cnt, cerr, terr, perr, tslots, since = 1000;
   logic [55:0] mon_next;
   logic [63:0] cur_pt;

   always #10 clk = ~clk;

   key_search_ctrl #(.KEY_W(56), .BLK_W(64), .LAT(LAT),
      .BIST_KEY(BKEY), .BIST_PT(BPT), .BIST_CT(BCT)) uut (
      .clk(clk), .rst_n(rst_n), .load_pair_i(load_pair),
      .pair_pt_i(pair_pt), .pair_ct_i(pair_ct),
      .start_key_i(start_key), .end_key_i(end_key),
      .go_i(go), .bist_req_i(bist_req), .irq_clr_i(irq_clr),
      .dp_vld_o(dp_vld), .dp_key_o(dp_key), .dp_text_o(dp_text),
      .dp_res_i(dp_res), .done_o(done), .irq_o(irq), .hit_key_o(hit_key),
      .overflow_o(ovf), .bist_done_o(bdone), .bist_pass_o(bpass));

   // toy cipher: each even/odd key pair maps the same way
   function automatic logic [63:0] toy(input logic [55:0] k, input logic [63:0] p);
      return p ^ {8'h00, k[55:1], 1'b0};
   endfunction

   logic [63:0] dps [LAT];
   always @(posedge clk) begin
      dps[0] <= toy(dp_key, dp_text) ^ ((fault && dp_text == BPT) ? 64'h1 : 64'h0);
      for (int i = 1; i < LAT; i++) dps[i] <= dps[i-1];
   end
   assign dp_res = dps[LAT-1];

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: run hung, got %0d expected below 150000", cyc);
         summary();
         $finish;
      end
   end

   // launch monitor
   always @(negedge clk) begin
      since++;
      if (dp_vld) begin
         if (dp_text == BPT) begin
            tslots++;
            since = 0;
         end else begin
            if (dp_key != mon_next) cerr++;
            if (dp_text != cur_pt) terr++;
            if (since <= LAT) perr++;
            mon_next = dp_key + 56'd1;
            mon_cnt++;
         end
      end
   end

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", what, act, exp);
      end
   endtask

   task automatic clear_irq();
      @(negedge clk) irq_clr = 1;
      @(negedge clk) irq_clr = 0;
   endtask

   task automatic wait_done();
      int n = 0;
      repeat (3) @(negedge clk);
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic run(input logic [55:0] s, input logic [55:0] e,
                      input logic [63:0] pt, input logic [63:0] ct,
                      input bit bist, input int bd, input string tag);
      logic [63:0] d;
      logic [55:0] base, first;
      int nh = 0;
      @(negedge clk) begin load_pair = 1; pair_pt = pt; pair_ct = ct; end
      @(negedge clk) load_pair = 0;
      clear_irq();
      mon_next = s; mon_cnt = 0; cerr = 0; terr = 0; perr = 0; tslots = 0;
      cur_pt = pt; since = 1000;
      start_key = s; end_key = e;
      @(negedge clk) go = 1;
      @(negedge clk) go = 0;
      if (bist) begin
         repeat (bd - 1) @(negedge clk);
         bist_req = 1;
         @(negedge clk) bist_req = 0;
      end
      wait_done();
      first = '0;
      d = pt ^ ct;
      if (d[63:56] == 8'h00 && d[0] == 1'b0) begin
         base = {d[55:1], 1'b0};
         if (base >= s && base <= e) begin nh++; first = base; end
         if (base + 56'd1 >= s && base + 56'd1 <= e) begin
            if (nh == 0) first = base + 56'd1;
            nh++;
         end
      end
      chk({tag, " R3 done after drain"}, 64'(done), 64'd1);
      chk({tag, " R3 no launch after done"}, 64'(dp_vld), 64'd0);
      chk({tag, " R2 keys launched"}, 64'(mon_cnt), 64'(e - s + 56'd1));
      chk({tag, " R2 key gaps"}, 64'(cerr), 64'd0);
      chk({tag, " R9 plaintext"}, 64'(terr), 64'd0);
      chk({tag, " R4 irq"}, 64'(irq), 64'(nh > 0));
      if (nh > 0) chk({tag, " R4 hit key"}, 64'(hit_key), 64'(first));
      chk({tag, " R6 overflow"}, 64'(ovf), 64'(nh > 1));
      if (bist) begin
         chk({tag, " R7 one test slot"}, 64'(tslots), 64'd1);
         chk({tag, " R7 pause held"}, 64'(perr), 64'd0);
         chk({tag, " R8 bist done"}, 64'(bdone), 64'd1);
         chk({tag, " R8 bist pass"}, 64'(bpass), 64'd1);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 dp_vld", 64'(dp_vld), 64'd0);
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 irq", 64'(irq), 64'd0);
      chk("R1 overflow", 64'(ovf), 64'd0);
      chk("R1 bist_done", 64'(bdone), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // two colliding hits: first captured, overflow raised (R4, R6)
      run(56'd100, 56'd131, 64'h0AB0_0000_0000_0000,
          64'h0AB0_0000_0000_0000 ^ {8'h00, 56'd110}, 0, 0, "dirA");
      clear_irq();
      chk("R6 irq cleared", 64'(irq), 64'd0);
      chk("R6 overflow cleared", 64'(ovf), 64'd0);

      // single hit on the very last key (R3, R4)
      run(56'd200, 56'd210, 64'h0AB0_1111_2222_3333,
          64'h0AB0_1111_2222_3333 ^ {8'h00, 56'd210}, 0, 0, "dirB");

      // single hit on first key, run continues after it (R5)
      run(56'd1021, 56'd1099, 64'h0AB0_5555_0000_0001,
          64'h0AB0_5555_0000_0001 ^ {8'h00, 56'd1020}, 0, 0, "dirC_R5");

      // self-test mid-run, no hit possible (R7, R8)
      run(56'd5000, 56'd5060, 64'h0AB0_2222_0000_0000,
          64'h5AB0_2222_0000_0000, 1, 12, "dirD_R7");

      // target equals test result: test slot must not interrupt (R8)
      run(56'd7000, 56'd7030, 64'h0AB0_3333_4444_5555, BCT, 1, 5, "dirE_R8");

      // failing self-test from idle (R8)
      fault = 1'b1;
      @(negedge clk) bist_req = 1;
      @(negedge clk) bist_req = 0;
      repeat (LAT + 6) @(negedge clk);
      chk("R8 failed test done", 64'(bdone), 64'd1);
      chk("R8 failed test flagged", 64'(bpass), 64'd0);
      chk("R8 failed test no irq", 64'(irq), 64'd0);
      fault = 1'b0;

      // random slices
      for (int it = 0; it < 24; it++) begin
         logic [55:0] s, e, t;
         logic [63:0] pt, ct;
         int len, bd;
         bit b;
         len = 1 + int'($urandom % 48);
         s   = {24'h0, 32'($urandom)};
         e   = s + 56'(len - 1);
         pt  = {16'h0AB0, 16'($urandom), 32'($urandom)};
         if ($urandom % 3 != 0) begin
            t  = s + 56'($urandom % len);
            ct = pt ^ {8'h00, t[55:1], 1'b0};
         end else begin
            ct = pt ^ {8'h5A, 24'($urandom), 32'($urandom)};
         end
         b  = ($urandom % 2) == 1;
         bd = 1 + int'($urandom % len);
         run(s, e, pt, ct, b, bd, "rnd");
      end

      summary();
      $finish;
   end

endmodule